// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-facing register file of a simple serial port. A host reaches it through a 32-bit word bus with byte enables. It holds control storage, a status/data-in word, a data-out register, and a set of raw, mask and acknowledge interrupt registers. Received bytes arrive on a valid/ready byte stream and queue in a small receive FIFO. Bytes written by the host leave on a one-cycle transmit strobe. A single level interrupt line reflects the masked interrupt status.

Software polls or takes an interrupt, then reads the status/data-in word. One address pops the oldest byte and a second address only peeks at it. The transmit interrupt bits are set on every data-out write. They are cleared through the acknowledge register, which has a special rule for the first acknowledge after a transmit. The receive interrupt bit is a level that follows FIFO occupancy. It is refreshed only on register writes and on received bytes.

Top module: `sio_regfile`

## Requirements
- R1: Word offsets (byte address >> 2): 0 tx control, 1 tx DMA enable, 2 rx control, 7 data out, 8 status with pop, 9 status peek, 11 interrupt mask, 12 acknowledge, 13 raw interrupt, 14 masked interrupt. The storage registers at 0, 1, 2, 7, 11 and 12 read back the stored value. Any other offset reads 0 and ignores writes, and so do writes to 8, 9 and 14.
- R2: An access is valid only when bus_be_i is 4'hF. Any other enable pattern makes a write have no effect and a read return 0 without popping the FIFO.
- R3: A status read returns bit 24 = 1, bit 22 = 1, bit 16 = FIFO not empty, and bits [7:0] = the oldest byte (0 when empty), with all other bits 0. A read at offset 8 removes that byte if the FIFO is not empty. A read at offset 9 leaves the FIFO unchanged.
- R4: The FIFO holds 16 bytes and returns them in arrival order. rx_ready_o is low while it holds 16, so a further byte is not taken.
- R5: rx_ready_o is high only when rx control bit 3 is set and the FIFO is not full. After reset, rx control reads 0x00010000, every other register reads 0, and irq_o is low.
- R6: A valid write to data out drives tx_valid_o high for one cycle on the next cycle, with tx_data_o equal to the written low byte. It also sets raw bits 0 and 1 and sets a transmit-pending flag.
- R7: An acknowledge write clears each raw bit set in the written value. If transmit-pending is set, bit 0 of the value is forced to 0 for that write and the flag is cleared. The adjusted value is stored as the acknowledge register.
- R8: The masked register equals raw AND mask, and irq_o is high exactly when it is non-zero.
- R9: Raw bit 3 is set to "FIFO not empty" after every valid register write and after every accepted byte. A pop read alone does not refresh it.
- R10: A valid write to the raw register loads the written value, except that bit 3 is then refreshed as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_be_i | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational in the request cycle |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receiver can take a byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 16-entry FIFO and a 6-bit byte address. With these values the whole register window and the unmapped holes inside it can be reached. The full-FIFO boundary is reached after sixteen received bytes. Random writes, reads and received bytes run the raw-interrupt refresh rule against pops, acknowledges and raw writes in many orders. Directed cases cover the reset state, the seventeenth byte, the acknowledge that follows a transmit, and a raw bit 3 that stays set after a pop.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
  localparam int unsigned W_TXCTRL = 0;
  localparam int unsigned W_TXDMA  = 1;
  localparam int unsigned W_RXCTRL = 2;
  localparam int unsigned W_DOUT   = 7;
  localparam int unsigned W_POP    = 8;
  localparam int unsigned W_PEEK   = 9;
  localparam int unsigned W_MASK   = 11;
  localparam int unsigned W_ACK    = 12;
  localparam int unsigned W_RAW    = 13;
  localparam int unsigned W_MASKED = 14;

  localparam int unsigned ST_AVAIL = 16;
  localparam int unsigned ST_IDLE  = 22;
  localparam int unsigned ST_READY = 24;

  localparam int unsigned RX_EN_BIT  = 3;
  localparam int unsigned IRQ_RX_BIT = 3;
  localparam logic [31:0] IRQ_TX_SET = 32'h3;
  localparam logic [31:0] RXCTRL_RST = 32'h0001_0000;

  typedef struct packed {
    logic txctrl;
    logic txdma;
    logic rxctrl;
    logic dout;
    logic pop;
    logic peek;
    logic mask;
    logic ack;
    logic raw;
    logic masked;
  } sio_sel_t;
endpackage

// File: rtl/sio_addr_dec.sv
`timescale 1ns/1ps
module sio_addr_dec
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              req_i,
  input  logic [3:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ok_o,
  output sio_sel_t          sel_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  logic [WORD_W-1:0] word;

  assign word = addr_i[ADDR_W-1:2];
  assign ok_o = req_i && (be_i == 4'hF);

  always_comb begin
    sel_o        = '0;
    sel_o.txctrl = (word == WORD_W'(W_TXCTRL));
    sel_o.txdma  = (word == WORD_W'(W_TXDMA));
    sel_o.rxctrl = (word == WORD_W'(W_RXCTRL));
    sel_o.dout   = (word == WORD_W'(W_DOUT));
    sel_o.pop    = (word == WORD_W'(W_POP));
    sel_o.peek   = (word == WORD_W'(W_PEEK));
    sel_o.mask   = (word == WORD_W'(W_MASK));
    sel_o.ack    = (word == WORD_W'(W_ACK));
    sel_o.raw    = (word == WORD_W'(W_RAW));
    sel_o.masked = (word == WORD_W'(W_MASKED));
  end
endmodule

// File: rtl/sio_rx_fifo.sv
`timescale 1ns/1ps
module sio_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_eff;

  assign pop_eff = pop_i && (cnt_q != '0);
  assign head_o  = (cnt_q != '0) ? mem_q[rd_q] : '0;
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= nxt(wr_q);
      end
      if (pop_eff) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_eff);
    end
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
`timescale 1ns/1ps
module sio_irq_ctrl
  import sio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dout_wr_i,
  input  logic        ack_wr_i,
  input  logic        raw_wr_i,
  input  logic        refresh_i,
  input  logic        rx_nonempty_i,
  input  logic [31:0] wdata_i,
  input  logic [31:0] mask_i,
  output logic [31:0] raw_o,
  output logic [31:0] masked_o,
  output logic [31:0] ack_o,
  output logic        pending_o,
  output logic        irq_o
);
  logic [31:0] raw_q, raw_d, ack_q, ack_d, ack_val;
  logic        pend_q, pend_d;

  always_comb begin
    raw_d   = raw_q;
    ack_d   = ack_q;
    pend_d  = pend_q;
    ack_val = wdata_i;
    if (dout_wr_i) begin
      raw_d  = raw_d | IRQ_TX_SET;
      pend_d = 1'b1;
    end
    if (ack_wr_i) begin
      // first ack after a transmit keeps tx bit 0
      if (pend_q) begin
        ack_val[0] = 1'b0;
        pend_d     = 1'b0;
      end
      ack_d = ack_val;
      raw_d = raw_d & ~ack_val;
    end
    if (raw_wr_i) raw_d = wdata_i;
    if (refresh_i) raw_d[IRQ_RX_BIT] = rx_nonempty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      ack_q  <= ack_d;
      pend_q <= pend_d;
    end
  end

  assign raw_o     = raw_q;
  assign ack_o     = ack_q;
  assign pending_o = pend_q;
  assign masked_o  = raw_q & mask_i;
  assign irq_o     = |masked_o;
endmodule

// File: rtl/sio_regfile.sv
`timescale 1ns/1ps
module sio_regfile
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [3:0]        bus_be_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  sio_sel_t         sel;
  logic             acc_ok, wr, rd;
  logic [31:0]      txctrl_q, txdma_q, rxctrl_q, dout_q, mask_q;
  logic [31:0]      raw, masked, ack;
  logic             pending;
  logic             tx_vld_q;
  logic [7:0]       tx_dat_q;
  logic [7:0]       head;
  logic [CNT_W-1:0] fifo_cnt, cnt_nxt;
  logic             rx_push, pop_req, pop_eff;
  logic [31:0]      status;

  sio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (bus_req_i),
    .be_i   (bus_be_i),
    .addr_i (bus_addr_i),
    .ok_o   (acc_ok),
    .sel_o  (sel)
  );

  assign wr = acc_ok && bus_we_i;
  assign rd = acc_ok && !bus_we_i;

  assign rx_ready_o = rxctrl_q[RX_EN_BIT] && (fifo_cnt != CNT_W'(DEPTH));
  assign rx_push    = rx_valid_i && rx_ready_o;
  assign pop_req    = rd && sel.pop;
  assign pop_eff    = pop_req && (fifo_cnt != '0);
  assign cnt_nxt    = fifo_cnt + CNT_W'(rx_push) - CNT_W'(pop_eff);

  sio_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (pop_req),
    .head_o  (head),
    .count_o (fifo_cnt)
  );

  sio_irq_ctrl u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dout_wr_i     (wr && sel.dout),
    .ack_wr_i      (wr && sel.ack),
    .raw_wr_i      (wr && sel.raw),
    .refresh_i     (wr || rx_push),
    .rx_nonempty_i (cnt_nxt != '0),
    .wdata_i       (bus_wdata_i),
    .mask_i        (mask_q),
    .raw_o         (raw),
    .masked_o      (masked),
    .ack_o         (ack),
    .pending_o     (pending),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txctrl_q <= '0;
      txdma_q  <= '0;
      rxctrl_q <= RXCTRL_RST;
      dout_q   <= '0;
      mask_q   <= '0;
      tx_vld_q <= 1'b0;
      tx_dat_q <= '0;
    end else begin
      tx_vld_q <= wr && sel.dout;
      if (wr && sel.dout) begin
        dout_q   <= bus_wdata_i;
        tx_dat_q <= bus_wdata_i[7:0];
      end
      if (wr && sel.txctrl) txctrl_q <= bus_wdata_i;
      if (wr && sel.txdma)  txdma_q  <= bus_wdata_i;
      if (wr && sel.rxctrl) rxctrl_q <= bus_wdata_i;
      if (wr && sel.mask)   mask_q   <= bus_wdata_i;
    end
  end

  assign tx_valid_o = tx_vld_q;
  assign tx_data_o  = tx_dat_q;

  always_comb begin
    status                = '0;
    status[7:0]           = head;
    status[ST_AVAIL]      = (fifo_cnt != '0);
    status[ST_IDLE]       = 1'b1;
    status[ST_READY]      = 1'b1;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      unique case (1'b1)
        sel.txctrl:          bus_rdata_o = txctrl_q;
        sel.txdma:           bus_rdata_o = txdma_q;
        sel.rxctrl:          bus_rdata_o = rxctrl_q;
        sel.dout:            bus_rdata_o = dout_q;
        sel.pop, sel.peek:   bus_rdata_o = status;
        sel.mask:            bus_rdata_o = mask_q;
        sel.ack:             bus_rdata_o = ack;
        sel.raw:             bus_rdata_o = raw;
        sel.masked:          bus_rdata_o = masked;
        default:             bus_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_regfile_chk.sv
`timescale 1ns/1ps
module sio_regfile_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_dout,
  input logic             wr_ack,
  input logic             rd_pop,
  input logic             rd_peek,
  input logic             rx_push,
  input logic             rx_en,
  input logic [31:0]      wdata,
  input logic [31:0]      raw,
  input logic [31:0]      mask,
  input logic             pending,
  input logic [CNT_W-1:0] cnt,
  input logic             rx_ready_o,
  input logic             tx_valid_o,
  input logic [7:0]       tx_data_o,
  input logic             irq_o
);
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH)); // R4
  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(DEPTH)) |-> !rx_ready_o); // R4
  AST_RX_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en |-> !rx_ready_o); // R5
  AST_PEEK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_peek && !rx_push) |=> $stable(cnt)); // R3
  AST_POP_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop && !rx_push && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
  AST_TX_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dout |=> (tx_valid_o && tx_data_o == $past(wdata[7:0]))); // R6
  AST_TX_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dout |=> !tx_valid_o); // R6
  AST_ACK_KEEPS_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack && pending && raw[0]) |=> raw[0]); // R7
  AST_TX_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dout && mask[0]) |=> irq_o); // R8
endmodule

bind sio_regfile sio_regfile_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_dout    (wr && sel.dout),
  .wr_ack     (wr && sel.ack),
  .rd_pop     (rd && sel.pop),
  .rd_peek    (rd && sel.peek),
  .rx_push    (rx_push),
  .rx_en      (rxctrl_q[3]),
  .wdata      (bus_wdata_i),
  .raw        (raw),
  .mask       (mask_q),
  .pending    (pending),
  .cnt        (fifo_cnt),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .irq_o      (irq_o)
);

// File: tb/sim_sio_regfile.sv
`timescale 1ns/1ps
module sim_sio_regfile;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [3:0]        be = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_data = '0;
  logic              rx_ready, tx_valid, irq;
  logic [7:0]        tx_data;

  int unsigned n_chk = 0, n_err = 0;

  // model state
  logic [7:0]  q[$];
  logic [31:0] m_txctrl, m_txdma, m_rxctrl, m_dout, m_mask, m_ack, m_raw;
  logic        m_pend;

  always #2.5 clk = ~clk;

  sio_regfile #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_be_i(be), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = 32'h0140_0000;
    if (q.size() != 0) s = s | 32'h0001_0000 | {24'h0, q[0]};
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input int unsigned w, input logic [3:0] b);
    if (b != 4'hF) return 32'h0;
    case (w)
      0: return m_txctrl;
      1: return m_txdma;
      2: return m_rxctrl;
      7: return m_dout;
      8, 9: return exp_status();
      11: return m_mask;
      12: return m_ack;
      13: return m_raw;
      14: return m_raw & m_mask;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input int unsigned w, input logic [31:0] d);
    logic [31:0] v;
    case (w)
      0: m_txctrl = d;
      1: m_txdma = d;
      2: m_rxctrl = d;
      7: begin m_dout = d; m_raw = m_raw | 32'h3; m_pend = 1'b1; end
      11: m_mask = d;
      12: begin
        v = d;
        if (m_pend) begin v[0] = 1'b0; m_pend = 1'b0; end
        m_ack = v;
        m_raw = m_raw & ~v;
      end
      13: m_raw = d;
      default: ;
    endcase
    m_raw[3] = (q.size() != 0);
  endfunction

  task automatic post_checks(input string tag);
    chk({tag, " R8 irq"}, {31'h0, irq}, {31'h0, |(m_raw & m_mask)});
    chk({tag, " R5 ready"}, {31'h0, rx_ready}, {31'h0, m_rxctrl[3] && (q.size() < DEPTH)});
  endtask

  task automatic bus_wr(input int unsigned w, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; be = b; addr = ADDR_W'(w << 2); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (b == 4'hF) model_write(w, d);
    if (b == 4'hF && w == 7) begin
      chk("R6 tx strobe", {31'h0, tx_valid}, 32'h1);
      chk("R6 tx byte", {24'h0, tx_data}, {24'h0, d[7:0]});
    end else begin
      chk("R6 no strobe", {31'h0, tx_valid}, 32'h0);
    end
    post_checks("wr");
  endtask

  task automatic bus_rd(input int unsigned w, input logic [3:0] b, input string tag);
    logic [31:0] got, exp;
    @(negedge clk);
    req = 1'b1; we = 1'b0; be = b; addr = ADDR_W'(w << 2);
    #1;
    got = rdata;
    exp = exp_read(w, b);
    chk(tag, got, exp);
    @(negedge clk);
    req = 1'b0;
    if (b == 4'hF && w == 8 && q.size() != 0) void'(q.pop_front());
    post_checks("rd");
  endtask

  task automatic rx_send(input logic [7:0] d);
    logic rdy;
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    #1;
    rdy = rx_ready;
    chk("R4 R5 ready at push", {31'h0, rdy}, {31'h0, m_rxctrl[3] && (q.size() < DEPTH)});
    @(negedge clk);
    rx_valid = 1'b0;
    if (rdy) begin
      q.push_back(d);
      m_raw[3] = 1'b1;
    end
    post_checks("rx");
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5E1A_0017));
    m_txctrl = '0; m_txdma = '0; m_rxctrl = 32'h0001_0000; m_dout = '0;
    m_mask = '0; m_ack = '0; m_raw = '0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    #1;
    chk("R5 reset irq", {31'h0, irq}, 32'h0);
    chk("R5 reset ready", {31'h0, rx_ready}, 32'h0);
    bus_rd(2, 4'hF, "R5 reset rxctrl");
    bus_rd(9, 4'hF, "R5 R3 reset status");
    bus_rd(13, 4'hF, "R5 reset raw");
    bus_rd(11, 4'hF, "R5 reset mask");

    // R5 disabled receiver drops bytes
    rx_send(8'hA5);
    bus_rd(9, 4'hF, "R5 disabled status");

    // R4 fill to 16, 17th refused, order kept
    bus_wr(2, 32'h0000_0008, 4'hF);
    for (int i = 0; i < 17; i++) rx_send(8'h10 + 8'(i));
    bus_rd(9, 4'hF, "R3 peek head");
    bus_rd(9, 4'hF, "R3 peek again");
    for (int i = 0; i < 16; i++) bus_rd(8, 4'hF, "R4 R3 pop order");
    bus_rd(8, 4'hF, "R3 pop empty");

    // R9 raw bit 3 not refreshed by a pop alone
    rx_send(8'h42);
    bus_rd(8, 4'hF, "R3 pop single");
    bus_rd(13, 4'hF, "R9 raw after pop");
    bus_wr(0, 32'h1234_5678, 4'hF);
    bus_rd(13, 4'hF, "R9 raw after write");

    // R6 R7 R8 transmit and ack rule
    bus_wr(11, 32'h0000_0003, 4'hF);
    bus_wr(7, 32'hCAFE_0155, 4'hF);
    bus_rd(13, 4'hF, "R6 raw tx bits");
    bus_rd(7, 4'hF, "R1 dout readback");
    bus_wr(12, 32'h0000_0003, 4'hF);
    bus_rd(12, 4'hF, "R7 ack stored adjusted");
    bus_rd(13, 4'hF, "R7 bit0 kept");
    bus_wr(12, 32'h0000_0001, 4'hF);
    bus_rd(13, 4'hF, "R7 bit0 cleared");

    // R10 raw write with bit 3 refresh
    bus_wr(13, 32'hFFFF_FFFF, 4'hF);
    bus_rd(13, 4'hF, "R10 raw write");
    bus_rd(14, 4'hF, "R8 masked");

    // R2 partial access
    rx_send(8'h77);
    bus_wr(11, 32'hFFFF_0000, 4'h3);
    bus_rd(11, 4'hF, "R2 partial write ignored");
    bus_rd(8, 4'h7, "R2 partial read zero");
    bus_rd(9, 4'hF, "R2 no pop on partial");

    // R1 unmapped and read-only
    bus_wr(5, 32'hDEAD_BEEF, 4'hF);
    bus_rd(5, 4'hF, "R1 unmapped");
    bus_wr(14, 32'hFFFF_FFFF, 4'hF);
    bus_rd(14, 4'hF, "R1 masked read-only");
    bus_rd(15, 4'hF, "R1 unmapped top");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned op = $urandom_range(0, 9);
      int unsigned w = $urandom_range(0, 15);
      logic [3:0] b = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      logic [31:0] d = $urandom();
      if (w == 2 && $urandom_range(0, 3) != 0) d[3] = 1'b1;
      if (op < 4) rx_send(8'($urandom()));
      else if (op < 7) bus_rd(w, b, "R1 R3 R9 random read");
      else if (op < 8) bus_rd(8, 4'hF, "R3 R4 random pop");
      else bus_wr(w, d, b);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule